// File: doc/BRIEF.md
# Configurable SPI Byte Shifter (Master or Slave)

This block moves one byte at a time over a serial peripheral link. It can act as the clock-driving end or the clock-following end, and a configuration input picks which. When it drives the clock, a write of a byte starts a transfer. The serial clock then advances by one edge on each pulse of an external rate tick. The byte goes out on the data-out line while the bits from the far end are collected. When it follows, the block tracks a serial clock and a select line from outside, both brought into its own clock domain. It collects the incoming line and presents its own byte on the return line.

Clock idle level, sampling phase and bit order are all configurable. The write path is double-buffered. A byte written during a transfer waits in a holding register. When the block drives the clock, the held byte starts the next transfer one cycle after the current one ends. When the block follows, the held byte is loaded for the next byte that the far end clocks. A start pulse fires when a driven transfer begins. A receive pulse fires when any transfer completes. Each pulse has its own interrupt enable.

Top module: `spi_shifter`

## Requirements
- R1: After reset, busy, rx_flag, tx_flag, tx_byte_done and rx_byte are 0, rd_data is 0, and sck_o equals cfg_cpol.
- R2: In master mode (cfg_slave=0), a wr_en pulse while idle sets busy and gives a one-cycle tx_flag on the next clock edge. irq_tx equals tx_flag when tx_ie=1 and stays 0 when tx_ie=0.
- R3: In master mode, each baud_tick during a transfer toggles sck_o. A byte takes exactly 16 toggles, and sck_o rests at cfg_cpol when idle.
- R4: On the edge that completes a byte, busy falls and rx_flag pulses for one cycle. rd_data then holds the received byte. tx_byte_done is set in master mode and rx_byte is set in slave mode. A later wr_en clears both.
- R5: With cfg_cpha=0, a bit is sampled on the first clock edge of its period and the output changes on the second. With cfg_cpha=1, the output changes on the first edge and the bit is sampled on the second. The first bit is driven before the first edge when cfg_cpha=0.
- R6: With cfg_lsb_first=1, bit 0 goes first in both directions. With cfg_lsb_first=0, bit 7 goes first.
- R7: A write during a master transfer is held. One cycle after busy falls, a new transfer starts with the held byte, with a new tx_flag. A second write before that start replaces the held byte.
- R8: In slave mode (cfg_slave=1), the block shifts on edges of the external sck_i while ssn_i is low. It samples mosi_i and drives miso_i's counterpart miso_o with the written byte. sck_i, ssn_i and mosi_i each pass through two synchronizer flops.
- R9: In slave mode, ssn_i rising before the 16th edge drops busy and gives no rx_flag. The bit count restarts, so the next full byte is received correctly.
- R10: In slave mode, a write during a transfer is held and becomes the outgoing byte of the next transfer.
- R11: irq_rx equals rx_flag when rx_ie=1 and stays 0 when rx_ie=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_slave | input | 1 | 0 = master, 1 = slave |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling phase select |
| cfg_lsb_first | input | 1 | 1 = bit 0 first |
| baud_tick | input | 1 | Master clock-edge enable pulse |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | DW | Byte to send |
| rd_data | output | DW | Last received byte |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_ie | input | 1 | Start interrupt enable |
| sck_o | output | 1 | Serial clock out (master) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| ssn_i | input | 1 | Active-low select in (slave) |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_o | output | 1 | Serial data out (slave) |
| busy | output | 1 | Transfer in progress |
| tx_byte_done | output | 1 | Master byte finished, buffer free |
| rx_byte | output | 1 | Slave byte received |
| rx_flag | output | 1 | One-cycle completion pulse |
| tx_flag | output | 1 | One-cycle master start pulse |
| irq_rx | output | 1 | Gated completion interrupt |
| irq_tx | output | 1 | Gated start interrupt |

## Verification
Two situations are the hardest to reach from the ports. The first is a master transfer chained out of the holding register after that register has been overwritten. It needs two writes to land inside a running byte, and a byte lasts only a few hundred cycles. The bench lines up its writes with the phase of the rate tick it generates. This gives the writes a known margin before the first clock edge, and the bench then catches the single idle cycle between the two transfers. The second situation is a slave abort in the middle of a byte. The bench acts as the far end and raises the select after five clock edges. It returns the clock to idle while deselected, then runs a full byte to show that the bit count restarted.

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_slave,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          cfg_lsb_first,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          rx_ie,
  input  logic          tx_ie,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  input  logic          sck_i,
  input  logic          ssn_i,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          busy,
  output logic          tx_byte_done,
  output logic          rx_byte,
  output logic          rx_flag,
  output logic          tx_flag,
  output logic          irq_rx,
  output logic          irq_tx
);
  localparam int NEDGE = 2 * DW;
  localparam int EW = $clog2(NEDGE);

  logic [DW-1:0] tx_sh, rx_sh, hold_q;
  logic          hold_v, lvl;
  logic [EW-1:0] edge_n;
  logic [2:0]    sck_s;
  logic [1:0]    ssn_s, mosi_s;

  wire sel     = ~ssn_s[1];
  wire step    = cfg_slave ? (sel & (sck_s[2] ^ sck_s[1])) : (busy & baud_tick);
  wire samp    = ~(edge_n[0] ^ cfg_cpha);
  wire shft    = ~samp & ~(cfg_cpha & (edge_n == '0));
  wire last    = (edge_n == EW'(NEDGE - 1));
  wire in_bit  = cfg_slave ? mosi_s[1] : miso_i;
  wire tx_bit  = cfg_lsb_first ? tx_sh[0] : tx_sh[DW-1];
  wire start_m = ~cfg_slave & ~busy & (wr_en | hold_v);

  wire [DW-1:0] rx_nx = cfg_lsb_first ? {in_bit, rx_sh[DW-1:1]} : {rx_sh[DW-2:0], in_bit};
  wire [DW-1:0] tx_nx = cfg_lsb_first ? {1'b0, tx_sh[DW-1:1]} : {tx_sh[DW-2:0], 1'b0};

  assign sck_o  = cfg_slave ? cfg_cpol : (cfg_cpol ^ lvl);
  assign mosi_o = ~cfg_slave & tx_bit;
  assign miso_o = cfg_slave & tx_bit;
  assign irq_rx = rx_flag & rx_ie;
  assign irq_tx = tx_flag & tx_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0; rx_sh <= '0; hold_q <= '0; hold_v <= 1'b0;
      lvl <= 1'b0; edge_n <= '0; rd_data <= '0;
      sck_s <= '0; ssn_s <= 2'b11; mosi_s <= '0;
      busy <= 1'b0; tx_byte_done <= 1'b0; rx_byte <= 1'b0;
      rx_flag <= 1'b0; tx_flag <= 1'b0;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      ssn_s  <= {ssn_s[0], ssn_i};
      mosi_s <= {mosi_s[0], mosi_i};
      rx_flag <= 1'b0;
      tx_flag <= 1'b0;

      if (wr_en) begin
        tx_byte_done <= 1'b0;
        rx_byte      <= 1'b0;
        if (cfg_slave & ~busy & ~hold_v) tx_sh <= wr_data;
        else if (!(start_m & ~hold_v)) begin
          hold_q <= wr_data;
          hold_v <= 1'b1;
        end
      end

      if (start_m) begin
        tx_sh   <= hold_v ? hold_q : wr_data;
        if (hold_v & ~wr_en) hold_v <= 1'b0;
        busy    <= 1'b1;
        edge_n  <= '0;
        lvl     <= 1'b0;
        tx_flag <= 1'b1;
      end else if (cfg_slave & ~sel) begin
        busy   <= 1'b0;
        edge_n <= '0;
      end else if (step) begin
        busy   <= 1'b1;
        edge_n <= edge_n + 1'b1;
        if (!cfg_slave) lvl <= ~lvl;
        if (samp) rx_sh <= rx_nx;
        if (shft) tx_sh <= tx_nx;
        if (last) begin
          busy    <= 1'b0;
          edge_n  <= '0;
          rd_data <= samp ? rx_nx : rx_sh;
          rx_flag <= 1'b1;
          if (cfg_slave) begin
            rx_byte <= 1'b1;
            if (hold_v) begin
              tx_sh <= hold_q;
              if (~wr_en) hold_v <= 1'b0;
            end
          end else begin
            tx_byte_done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_shifter_chk.sv
module spi_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_slave,
  input logic cfg_cpol,
  input logic busy,
  input logic sck_o,
  input logic rx_flag,
  input logic tx_flag,
  input logic tx_byte_done,
  input logic rx_byte
);
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && $rose(busy)) |-> tx_flag);

  a_r4_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag |-> $fell(busy));

  a_r3_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && !busy) |-> (sck_o == cfg_cpol));

  a_r4_done_with_rx: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_byte_done) || $rose(rx_byte)) |-> rx_flag);

  a_r8_no_start_in_slave: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_slave && $past(cfg_slave)) |-> !tx_flag);

  a_r2_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_flag && tx_flag));
endmodule

bind spi_shifter spi_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_cpol(cfg_cpol),
  .busy(busy), .sck_o(sck_o), .rx_flag(rx_flag), .tx_flag(tx_flag),
  .tx_byte_done(tx_byte_done), .rx_byte(rx_byte)
);

// File: tb/tb_spi_shifter.sv
`timescale 1ns/1ps
module tb_spi_shifter;
  logic clk = 0, rst_n = 0;
  logic cfg_slave = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0;
  logic baud_tick = 0, wr_en = 0, rx_ie = 1, tx_ie = 1;
  logic [7:0] wr_data = 0, rd_data;
  logic sck_o, mosi_o, miso_i = 0, sck_i = 0, ssn_i = 1, mosi_i = 0, miso_o;
  logic busy, tx_byte_done, rx_byte, rx_flag, tx_flag, irq_rx, irq_tx;
  int checks = 0, fails = 0, rx_cnt = 0;
  logic [3:0] tk = 0;

  always #2.5 clk = ~clk;

  spi_shifter #(.DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .baud_tick(baud_tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .rx_ie(rx_ie), .tx_ie(tx_ie),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i), .ssn_i(ssn_i),
    .mosi_i(mosi_i), .miso_o(miso_o), .busy(busy), .tx_byte_done(tx_byte_done),
    .rx_byte(rx_byte), .rx_flag(rx_flag), .tx_flag(tx_flag), .irq_rx(irq_rx), .irq_tx(irq_tx));

  always @(negedge clk) begin
    tk <= tk + 4'd1;
    baud_tick <= (tk == 4'd15);
  end
  always @(posedge clk) if (rx_flag) rx_cnt <= rx_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bp(input int j);
    return cfg_lsb_first ? j : 7 - j;
  endfunction

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // R2: master start on a write, aligned just after a tick
  task automatic m_write(input logic [7:0] d);
    wait (baud_tick); @(negedge clk); @(negedge clk);
    wr_en = 1; wr_data = d;
    @(posedge clk); #1; wr_en = 0;
    chk("R2 busy after write", busy, 1);
    chk("R2 tx_flag at start", tx_flag, 1);
    chk("R2 irq_tx gating", irq_tx, tx_ie);
    chk("R4 tx_byte_done cleared by write", tx_byte_done, 0);
  endtask

  // R3 R5 R6: bench plays the far end of a master transfer
  task automatic m_serve(input logic [7:0] exp_tx, input logic [7:0] slv);
    logic [7:0] got = 0;
    if (!cfg_cpha) miso_i = slv[bp(0)];
    for (int k = 0; k < 16; k++) begin
      @(sck_o); #1;
      if (cfg_cpha ? (k % 2 == 1) : (k % 2 == 0)) got[bp(k / 2)] = mosi_o;
      if (!cfg_cpha && (k % 2 == 1) && ((k + 1) / 2 < 8)) miso_i = slv[bp((k + 1) / 2)];
      if (cfg_cpha && (k % 2 == 0)) miso_i = slv[bp(k / 2)];
    end
    chk("R4 rx_flag at 16th edge", rx_flag, 1);
    chk("R4 busy low at end", busy, 0);
    chk("R4 rd_data received", rd_data, slv);
    chk("R4 tx_byte_done set", tx_byte_done, 1);
    chk("R11 irq_rx gating", irq_rx, rx_ie);
    chk("R5 R6 mosi byte", got, exp_tx);
    chk("R3 sck idle level", sck_o, cfg_cpol);
  endtask

  task automatic master_run(input logic pol, input logic pha, input logic lsb,
                            input logic [7:0] tx, input logic [7:0] slv);
    @(negedge clk); cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb;
    m_write(tx);
    m_serve(tx, slv);
  endtask

  // R7: chained transfer through the holding register, with overwrite
  task automatic chain_run();
    @(negedge clk); cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0;
    m_write(8'h11);
    do_write(8'h22);
    do_write(8'h33);
    m_serve(8'h11, 8'hA0);
    @(posedge clk); #1;
    chk("R7 held byte starts next cycle", busy, 1);
    chk("R7 tx_flag for chained start", tx_flag, 1);
    m_serve(8'h33, 8'h0F);
    repeat (60) @(negedge clk);
    chk("R7 no third transfer", busy, 0);
  endtask

  // R8 R9 R10: bench drives the clock as the far end
  task automatic s_xfer(input logic [7:0] m_byte, input logic [7:0] exp_miso, input int nedges,
                        input logic mid_wr, input logic [7:0] mid_data);
    logic [7:0] got = 0;
    int cnt0 = rx_cnt;
    @(negedge clk); ssn_i = 0;
    repeat (8) @(negedge clk);
    if (!cfg_cpha) mosi_i = m_byte[bp(0)];
    for (int k = 0; k < nedges; k++) begin
      sck_i = ~sck_i;
      if (cfg_cpha ? (k % 2 == 1) : (k % 2 == 0)) got[bp(k / 2)] = miso_o;
      if (!cfg_cpha && (k % 2 == 1) && ((k + 1) / 2 < 8)) mosi_i = m_byte[bp((k + 1) / 2)];
      if (cfg_cpha && (k % 2 == 0)) mosi_i = m_byte[bp(k / 2)];
      if (k == 15) begin
        repeat (3) @(posedge clk); #1;
        chk("R4 slave rx_flag", rx_flag, 1);
        chk("R8 slave rd_data", rd_data, m_byte);
        chk("R4 rx_byte set", rx_byte, 1);
        chk("R8 slave miso byte", got, exp_miso);
        repeat (6) @(negedge clk);
      end else if (mid_wr && k == 8) begin
        @(negedge clk); wr_en = 1; wr_data = mid_data;
        @(negedge clk); wr_en = 0;
        repeat (6) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
    end
    if (nedges < 16) begin
      chk("R9 busy during partial byte", busy, 1);
      ssn_i = 1;
      repeat (6) @(negedge clk);
      chk("R9 abort drops busy", busy, 0);
      chk("R9 abort gives no rx_flag", rx_cnt, cnt0);
      sck_i = cfg_cpol;
      repeat (6) @(negedge clk);
    end else begin
      ssn_i = 1;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic slave_cfg(input logic pol, input logic pha, input logic lsb);
    @(negedge clk); cfg_slave = 1; cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb;
    sck_i = pol;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 busy reset", busy, 0);
    chk("R1 rd_data reset", rd_data, 0);
    chk("R1 flags reset", {rx_flag, tx_flag, tx_byte_done, rx_byte}, 0);
    chk("R1 sck_o idle", sck_o, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    master_run(0, 0, 0, 8'hA5, 8'h3C);
    rx_ie = 0; tx_ie = 0;
    master_run(1, 1, 1, 8'h96, 8'h5A);
    rx_ie = 1; tx_ie = 1;
    master_run(0, 1, 0, 8'hC1, 8'h7E);
    master_run(1, 0, 1, 8'h2B, 8'hD4);
    chain_run();

    slave_cfg(0, 0, 0);
    do_write(8'hC3);
    s_xfer(8'h81, 8'hC3, 16, 1, 8'h7E);
    chk("R10 held byte idle after load", busy, 0);
    s_xfer(8'h42, 8'h7E, 16, 0, 8'h00);
    slave_cfg(1, 1, 1);
    do_write(8'h4D);
    s_xfer(8'hE2, 8'h4D, 16, 0, 8'h00);
    do_write(8'h55);
    s_xfer(8'h00, 8'h00, 5, 0, 8'h00);
    do_write(8'h99);
    s_xfer(8'h17, 8'h99, 16, 0, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule